// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits behind a DRAM request front end and turns one already decoded request (bank, row, column and direction) into a legal stream of DRAM commands. It remembers which row, if any, is open in each of the eight banks. For each request it decides whether the access is a row hit, a hit on a closed bank, or a row conflict. It then issues only the commands that case needs, and it holds each command back until every timing rule that applies to it is met. A request can also ask for a refresh. In that case the block closes every open bank and then issues REFRESH.

Requests arrive on a valid/ready handshake, one at a time. The command, bank and address outputs are registered. They show a NOP whenever no command goes out. A one-cycle done pulse marks the cycle in which the request's column command, or its REFRESH, appears. A per-request flag picks the page policy. Close-page shuts the row right after the access. Open-page leaves the row open for later hits. All timing values are parameters.

Top module: `dram_cmd_sequencer`

## Requirements
- R1: After reset the command output is NOP (code 0), done is low, req_ready is high and every bank is closed, so the first access to any bank starts with ACTIVATE.
- R2: A request whose row is already open in its bank issues only the READ or WRITE, with no ACTIVATE and no PRECHARGE ahead of it.
- R3: A request to a bank holding a different row issues PRECHARGE to that bank, then ACTIVATE with the new row, then the column command.
- R4: A request to a closed bank issues ACTIVATE then the column command. When no earlier command constrains it, ACTIVATE appears two cycles after the accepting clock edge and the column command follows exactly T_RCD cycles after ACTIVATE.
- R5: The page policy is captured at acceptance from close_page. When it is 1, a PRECHARGE to the same bank follows the column command before the next request is taken. When it is 0, the row stays open.
- R6: A READ or WRITE comes at least T_RCD cycles after its bank's ACTIVATE. A PRECHARGE comes at least T_RAS cycles after its bank's ACTIVATE.
- R7: An ACTIVATE comes at least T_RP cycles after its bank's PRECHARGE and at least T_RAS+T_RP cycles after that bank's previous ACTIVATE.
- R8: No T_FAW-cycle span holds more than four ACTIVATE commands. This means a fifth ACTIVATE comes at least T_FAW cycles after the fourth one before it.
- R9: Column commands are at least T_CCD cycles apart. A READ comes at least T_WEND+T_WTR cycles after the last WRITE.
- R10: A PRECHARGE comes at least T_WEND+T_WR cycles after the last WRITE to the same bank.
- R11: A refresh request precharges every open bank in ascending bank order, then issues REFRESH (bank field 0). REFRESH waits until all banks are closed and T_RP has elapsed since each PRECHARGE. Afterwards all banks are closed, and no ACTIVATE follows within T_RFC cycles.
- R12: done is high for exactly the cycles whose command is READ, WRITE or REFRESH. A request is taken only on a clock edge where req_valid and req_ready are both high, and every command a request needs has issued before req_ready rises again.
- R13: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5. cmd_addr_o carries the row on ACTIVATE, the column on READ and WRITE, and zero on PRECHARGE and REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| close_page | input | 1 | Page policy for the offered request: 1 closes the row after the access |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_refresh | input | 1 | The offered request is a refresh |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 10 | Target column |
| cmd_o | output | 3 | Command code (see R13) |
| cmd_bank_o | output | 3 | Bank addressed by the command |
| cmd_addr_o | output | 14 | Row or column address of the command |
| done_o | output | 1 | Pulses with the column command or REFRESH |

## Verification
The bench keeps its own shadow of open rows and derives, for each request, the exact command list the design must produce. A design that confuses a hit with a conflict, forgets to reopen a row, or skips the close-page precharge shows up as a sequence mismatch. Every observed command is also timed against its own history of activates, precharges, writes and refreshes. This catches a dropped or shortened counter, such as a fifth activate squeezed into the four-activate window, a read too soon after a write, or a precharge that cuts off write recovery. A directed first access pins the exact activate and column latency, so a design that waits longer than needed fails as well. Refresh is exercised with several banks open, so a design that closes them in the wrong order, or refreshes over an open bank, is caught.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int BANKS  = 8;
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TCNT_W = 8;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dcmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic              refr;
        logic              close;
    } req_t;

    // Value loaded into a down-counter so that the next command waits n cycles.
    function automatic logic [TCNT_W-1:0] tload(int unsigned n);
        return (n == 0) ? '0 : TCNT_W'(n - 1);
    endfunction

    function automatic logic [TCNT_W-1:0] tdec(logic [TCNT_W-1:0] c);
        return (c == '0) ? c : c - 1'b1;
    endfunction

endpackage

// File: rtl/dseq_bank.sv
module dseq_bank
    import dseq_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RAS = 7,
    parameter int T_RP  = 3,
    parameter int T_RC  = 10,
    parameter int T_WRP = 7,
    parameter int T_RFC = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             wr_i,
    input  logic             pre_i,
    input  logic             ref_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o,
    output logic             rp_done_o
);

    logic [TCNT_W-1:0] rcd_c, ras_c, rp_c, rc_c, wrp_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_c  <= '0;
            ras_c  <= '0;
            rp_c   <= '0;
            rc_c   <= '0;
            wrp_c  <= '0;
            open_o <= 1'b0;
            row_o  <= '0;
        end else begin
            rcd_c <= act_i ? tload(T_RCD) : tdec(rcd_c);
            ras_c <= act_i ? tload(T_RAS) : tdec(ras_c);
            rc_c  <= act_i ? tload(T_RC)  : tdec(rc_c);
            wrp_c <= wr_i  ? tload(T_WRP) : tdec(wrp_c);
            if (pre_i)      rp_c <= tload(T_RP);
            else if (ref_i) rp_c <= tload(T_RFC);
            else            rp_c <= tdec(rp_c);
            if (act_i) begin
                open_o <= 1'b1;
                row_o  <= row_i;
            end else if (pre_i || ref_i) begin
                open_o <= 1'b0;
            end
        end
    end

    assign col_ok_o  = (rcd_c == '0);
    assign pre_ok_o  = (ras_c == '0) && (wrp_c == '0);
    assign act_ok_o  = (rp_c == '0) && (rc_c == '0);
    assign rp_done_o = (rp_c == '0);

endmodule

// File: rtl/dseq_bus_timer.sv
module dseq_bus_timer
    import dseq_pkg::*;
#(
    parameter int T_CCD = 2,
    parameter int T_W2R = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic col_i,
    input  logic wr_i,
    output logic rd_ok_o,
    output logic wr_ok_o
);

    logic [TCNT_W-1:0] ccd_c, w2r_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccd_c <= '0;
            w2r_c <= '0;
        end else begin
            ccd_c <= col_i ? tload(T_CCD) : tdec(ccd_c);
            w2r_c <= wr_i  ? tload(T_W2R) : tdec(w2r_c);
        end
    end

    assign wr_ok_o = (ccd_c == '0);
    assign rd_ok_o = (ccd_c == '0) && (w2r_c == '0);

endmodule

// File: rtl/dseq_faw.sv
module dseq_faw #(
    parameter int T_FAW    = 30,
    parameter int WIN_ACTS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    output logic ok_o
);

    localparam int TS_W = $clog2(T_FAW + 1) + 1;

    logic [TS_W-1:0]     now;
    logic [TS_W-1:0]     stamp [WIN_ACTS];
    logic [WIN_ACTS-1:0] vld;
    logic [WIN_ACTS-1:0] aged;

    always_comb begin
        for (int i = 0; i < WIN_ACTS; i++) begin
            aged[i] = vld[i] && ((now - stamp[i]) >= TS_W'(T_FAW));
        end
    end

    assign ok_o = !vld[WIN_ACTS-1] || aged[WIN_ACTS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
            vld <= '0;
            for (int i = 0; i < WIN_ACTS; i++) stamp[i] <= '0;
        end else begin
            now <= now + 1'b1;
            if (act_i) begin
                stamp[0] <= now;
                vld[0]   <= 1'b1;
                for (int i = 1; i < WIN_ACTS; i++) begin
                    stamp[i] <= stamp[i-1];
                    vld[i]   <= vld[i-1] && !aged[i-1];
                end
            end else begin
                for (int i = 0; i < WIN_ACTS; i++) vld[i] <= vld[i] && !aged[i];
            end
        end
    end

endmodule

// File: rtl/dram_cmd_sequencer.sv
module dram_cmd_sequencer
    import dseq_pkg::*;
#(
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 7,
    parameter int T_RP   = 3,
    parameter int T_RFC  = 12,
    parameter int T_FAW  = 30,
    parameter int T_CCD  = 2,
    parameter int T_WEND = 4,
    parameter int T_WTR  = 2,
    parameter int T_WR   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_refresh,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              done_o
);

    localparam int T_RC  = T_RAS + T_RP;
    localparam int T_W2R = T_WEND + T_WTR;
    localparam int T_WRP = T_WEND + T_WR;

    seq_state_e        state, nx_state;
    req_t              cur;
    dcmd_e             nx_cmd;
    logic [BANK_W-1:0] nx_bank, lo_bank;
    logic [ADDR_W-1:0] nx_addr;
    logic              nx_done;

    logic [BANKS-1:0]  open_vec, col_ok, pre_ok, act_ok, rp_done;
    logic [ROW_W-1:0]  row_arr [BANKS];
    logic              rd_ok, wr_ok, faw_ok;
    logic              is_col;

    assign is_col = (nx_cmd == CMD_RD) || (nx_cmd == CMD_WR);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit_b;
        assign hit_b = (nx_bank == BANK_W'(b));
        dseq_bank #(
            .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
            .T_RC(T_RC), .T_WRP(T_WRP), .T_RFC(T_RFC)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_i    (hit_b && (nx_cmd == CMD_ACT)),
            .wr_i     (hit_b && (nx_cmd == CMD_WR)),
            .pre_i    (hit_b && (nx_cmd == CMD_PRE)),
            .ref_i    (nx_cmd == CMD_REF),
            .row_i    (cur.row),
            .open_o   (open_vec[b]),
            .row_o    (row_arr[b]),
            .col_ok_o (col_ok[b]),
            .pre_ok_o (pre_ok[b]),
            .act_ok_o (act_ok[b]),
            .rp_done_o(rp_done[b])
        );
    end

    dseq_bus_timer #(.T_CCD(T_CCD), .T_W2R(T_W2R)) u_bus (
        .clk    (clk),
        .rst    (rst),
        .col_i  (is_col),
        .wr_i   (nx_cmd == CMD_WR),
        .rd_ok_o(rd_ok),
        .wr_ok_o(wr_ok)
    );

    dseq_faw #(.T_FAW(T_FAW), .WIN_ACTS(4)) u_faw (
        .clk  (clk),
        .rst  (rst),
        .act_i(nx_cmd == CMD_ACT),
        .ok_o (faw_ok)
    );

    // Lowest-numbered open bank, used to close banks in order before refresh.
    always_comb begin
        lo_bank = '0;
        for (int b = BANKS - 1; b >= 0; b--) begin
            if (open_vec[b]) lo_bank = BANK_W'(b);
        end
    end

    always_comb begin
        nx_cmd   = CMD_NOP;
        nx_bank  = cur.bank;
        nx_addr  = '0;
        nx_done  = 1'b0;
        nx_state = state;
        case (state)
            ST_IDLE: if (req_valid) nx_state = ST_RUN;
            ST_RUN: begin
                if (cur.refr) begin
                    if (|open_vec) begin
                        nx_bank = lo_bank;
                        if (pre_ok[lo_bank]) nx_cmd = CMD_PRE;
                    end else if (&rp_done) begin
                        nx_cmd   = CMD_REF;
                        nx_bank  = '0;
                        nx_done  = 1'b1;
                        nx_state = ST_IDLE;
                    end
                end else if (open_vec[cur.bank]) begin
                    if (row_arr[cur.bank] == cur.row) begin
                        if (col_ok[cur.bank] && (cur.wr ? wr_ok : rd_ok)) begin
                            nx_cmd   = cur.wr ? CMD_WR : CMD_RD;
                            nx_addr  = ADDR_W'(cur.col);
                            nx_done  = 1'b1;
                            nx_state = cur.close ? ST_CLOSE : ST_IDLE;
                        end
                    end else if (pre_ok[cur.bank]) begin
                        nx_cmd = CMD_PRE;
                    end
                end else if (act_ok[cur.bank] && faw_ok) begin
                    nx_cmd  = CMD_ACT;
                    nx_addr = ADDR_W'(cur.row);
                end
            end
            ST_CLOSE: begin
                if (pre_ok[cur.bank]) begin
                    nx_cmd   = CMD_PRE;
                    nx_state = ST_IDLE;
                end
            end
            default: nx_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            cmd_o      <= CMD_NOP;
            cmd_bank_o <= '0;
            cmd_addr_o <= '0;
            done_o     <= 1'b0;
        end else begin
            state      <= nx_state;
            cmd_o      <= nx_cmd;
            cmd_bank_o <= nx_bank;
            cmd_addr_o <= nx_addr;
            done_o     <= nx_done;
            if (state == ST_IDLE && req_valid) begin
                cur <= '{bank: req_bank, row: req_row, col: req_col,
                         wr: req_write, refr: req_refresh, close: close_page};
            end
        end
    end

    assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk
    import dseq_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RAS = 7,
    parameter int T_RP  = 3,
    parameter int T_RC  = 10,
    parameter int T_RFC = 12,
    parameter int T_FAW = 30,
    parameter int T_CCD = 2,
    parameter int T_W2R = 6,
    parameter int T_WRP = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic              done
);

    function automatic logic [15:0] sinc(logic [15:0] x);
        return (&x) ? x : x + 16'd1;
    endfunction

    logic is_act, is_col, is_rd, is_ref;
    assign is_act = (cmd == CMD_ACT);
    assign is_rd  = (cmd == CMD_RD);
    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign is_ref = (cmd == CMD_REF);

    logic [15:0] s_col, s_wr, s_ref;
    logic [15:0] act_age [4];

    always_ff @(posedge clk) begin
        if (rst) begin
            s_col <= '1;
            s_wr  <= '1;
            s_ref <= '1;
            for (int i = 0; i < 4; i++) act_age[i] <= '1;
        end else begin
            s_col <= is_col ? 16'd1 : sinc(s_col);
            s_wr  <= (cmd == CMD_WR) ? 16'd1 : sinc(s_wr);
            s_ref <= is_ref ? 16'd1 : sinc(s_ref);
            if (is_act) begin
                act_age[0] <= 16'd1;
                for (int i = 1; i < 4; i++) act_age[i] <= sinc(act_age[i-1]);
            end else begin
                for (int i = 0; i < 4; i++) act_age[i] <= sinc(act_age[i]);
            end
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bk
        logic        sel;
        logic [15:0] s_act, s_pre, s_wrb;
        assign sel = (bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                s_act <= '1;
                s_pre <= '1;
                s_wrb <= '1;
            end else begin
                s_act <= (is_act && sel) ? 16'd1 : sinc(s_act);
                s_pre <= ((cmd == CMD_PRE) && sel) ? 16'd1 : sinc(s_pre);
                s_wrb <= ((cmd == CMD_WR) && sel) ? 16'd1 : sinc(s_wrb);
            end
        end

        p_rcd_r6: assert property (@(posedge clk) disable iff (rst)
            (is_col && sel) |-> (s_act >= 16'(T_RCD)));
        p_ras_r6: assert property (@(posedge clk) disable iff (rst)
            ((cmd == CMD_PRE) && sel) |-> (s_act >= 16'(T_RAS)));
        p_rp_r7: assert property (@(posedge clk) disable iff (rst)
            (is_act && sel) |-> (s_pre >= 16'(T_RP)));
        p_rc_r7: assert property (@(posedge clk) disable iff (rst)
            (is_act && sel) |-> (s_act >= 16'(T_RC)));
        p_wr_pre_r10: assert property (@(posedge clk) disable iff (rst)
            ((cmd == CMD_PRE) && sel) |-> (s_wrb >= 16'(T_WRP)));
        p_ref_rp_r11: assert property (@(posedge clk) disable iff (rst)
            is_ref |-> (s_pre >= 16'(T_RP)));
    end

    p_faw_r8: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (act_age[3] >= 16'(T_FAW)));
    p_ccd_r9: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (s_col >= 16'(T_CCD)));
    p_wtr_r9: assert property (@(posedge clk) disable iff (rst)
        is_rd |-> (s_wr >= 16'(T_W2R)));
    p_rfc_r11: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (s_ref >= 16'(T_RFC)));
    p_done_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (is_col || is_ref));
    p_done_cmd_r12: assert property (@(posedge clk) disable iff (rst)
        (is_col || is_ref) |-> done);
    p_code_r13: assert property (@(posedge clk) disable iff (rst)
        cmd <= 3'd5);

endmodule

bind dram_cmd_sequencer dseq_chk #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RAS + T_RP),
    .T_RFC(T_RFC), .T_FAW(T_FAW), .T_CCD(T_CCD),
    .T_W2R(T_WEND + T_WTR), .T_WRP(T_WEND + T_WR)
) u_chk (
    .clk (clk),
    .rst (rst),
    .cmd (cmd_o),
    .bank(cmd_bank_o),
    .done(done_o)
);

// File: tb/test_dram_cmd_sequencer.sv
module test_dram_cmd_sequencer;
    import dseq_pkg::*;

    localparam int T_RCD  = 3;
    localparam int T_RAS  = 7;
    localparam int T_RP   = 3;
    localparam int T_RFC  = 12;
    localparam int T_FAW  = 30;
    localparam int T_CCD  = 2;
    localparam int T_WEND = 4;
    localparam int T_WTR  = 2;
    localparam int T_WR   = 3;
    localparam int T_RC   = T_RAS + T_RP;
    localparam int EQ     = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              close_page = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_refresh = 1'b0;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [2:0]        cmd_o;
    logic [BANK_W-1:0] cmd_bank_o;
    logic [ADDR_W-1:0] cmd_addr_o;
    logic              done_o;

    dram_cmd_sequencer #(
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RFC(T_RFC), .T_FAW(T_FAW),
        .T_CCD(T_CCD), .T_WEND(T_WEND), .T_WTR(T_WTR), .T_WR(T_WR)
    ) i_dram_cmd_sequencer (
        .clk(clk), .rst(rst), .close_page(close_page), .req_valid(req_valid),
        .req_ready(req_ready), .req_refresh(req_refresh), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .cmd_o(cmd_o),
        .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit mopen [BANKS];
    int mrow  [BANKS];
    int l_act [BANKS];
    int l_pre [BANKS];
    int l_wrb [BANKS];
    int l_col, l_wr, l_ref;
    int hist [4];
    int e_cmd [EQ];
    int e_bank [EQ];
    int e_addr [EQ];
    int eh = 0, et = 0;
    int acc_cyc = 0, obs_act_cyc = 0, obs_col_cyc = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(int c, int b, int a);
        e_cmd[et % EQ]  = c;
        e_bank[et % EQ] = b;
        e_addr[et % EQ] = a;
        et++;
    endtask

    // Monitor: times every observed command against the rules and the expected list.
    always @(negedge clk) begin
        int c, b, a;
        bit exp_done;
        if (mon_on) begin
            cyc++;
            c = int'(cmd_o);
            b = int'(cmd_bank_o);
            a = int'(cmd_addr_o);
            exp_done = (c == 2) || (c == 3) || (c == 5);
            chk(done_o == exp_done, "R12 done pulse", int'(done_o), int'(exp_done));
            if (c != 0) begin
                if (eh == et) begin
                    chk(1'b0, "R12 command with no pending request", c, 0);
                end else begin
                    chk(c == e_cmd[eh % EQ], "R13 command code in sequence", c, e_cmd[eh % EQ]);
                    chk(b == e_bank[eh % EQ], "R13 command bank", b, e_bank[eh % EQ]);
                    chk(a == e_addr[eh % EQ], "R13 command address", a, e_addr[eh % EQ]);
                    eh++;
                end
                case (c)
                    1: begin
                        chk(!mopen[b], "R7 ACT to an open bank", 1, 0);
                        chk(cyc - l_pre[b] >= T_RP, "R7 tRP", cyc - l_pre[b], T_RP);
                        chk(cyc - l_act[b] >= T_RC, "R7 tRC", cyc - l_act[b], T_RC);
                        chk(cyc - l_ref >= T_RFC, "R11 tRFC", cyc - l_ref, T_RFC);
                        chk(cyc - hist[3] >= T_FAW, "R8 tFAW", cyc - hist[3], T_FAW);
                        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
                        hist[0] = cyc;
                        l_act[b] = cyc;
                        mopen[b] = 1'b1;
                        mrow[b] = a;
                        obs_act_cyc = cyc;
                    end
                    2, 3: begin
                        chk(mopen[b], "R2 column command to closed bank", 0, 1);
                        chk(cyc - l_act[b] >= T_RCD, "R6 tRCD", cyc - l_act[b], T_RCD);
                        chk(cyc - l_col >= T_CCD, "R9 tCCD", cyc - l_col, T_CCD);
                        if (c == 2)
                            chk(cyc - l_wr >= T_WEND + T_WTR, "R9 tWTR", cyc - l_wr, T_WEND + T_WTR);
                        l_col = cyc;
                        if (c == 3) begin
                            l_wr = cyc;
                            l_wrb[b] = cyc;
                        end
                        obs_col_cyc = cyc;
                    end
                    4: begin
                        chk(mopen[b], "R3 PRE to closed bank", 0, 1);
                        chk(cyc - l_act[b] >= T_RAS, "R6 tRAS", cyc - l_act[b], T_RAS);
                        chk(cyc - l_wrb[b] >= T_WEND + T_WR, "R10 tWR", cyc - l_wrb[b], T_WEND + T_WR);
                        mopen[b] = 1'b0;
                        l_pre[b] = cyc;
                    end
                    5: begin
                        for (int k = 0; k < BANKS; k++) begin
                            chk(!mopen[k], "R11 REF with bank open", k, -1);
                            chk(cyc - l_pre[k] >= T_RP, "R11 REF before tRP", cyc - l_pre[k], T_RP);
                        end
                        l_ref = cyc;
                    end
                    default: chk(1'b0, "R13 undefined command code", c, 0);
                endcase
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk); #1;
        while (!(req_ready && eh == et)) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic send(bit refr, bit wr, int bank, int row, int col, bit cls);
        wait_idle();
        req_valid   = 1'b1;
        req_refresh = refr;
        req_write   = wr;
        req_bank    = BANK_W'(bank);
        req_row     = ROW_W'(row);
        req_col     = COL_W'(col);
        close_page  = cls;
        @(posedge clk); #1;
        req_valid = 1'b0;
        acc_cyc = cyc;
        if (refr) begin
            for (int k = 0; k < BANKS; k++) if (mopen[k]) push(4, k, 0);
            push(5, 0, 0);
        end else begin
            if (mopen[bank] && mrow[bank] != row) push(4, bank, 0);
            if (!mopen[bank] || mrow[bank] != row) push(1, bank, row);
            push(wr ? 3 : 2, bank, col);
            if (cls) push(4, bank, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12 watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd90210));
        for (int k = 0; k < BANKS; k++) begin
            mopen[k] = 1'b0;
            mrow[k]  = 0;
            l_act[k] = -1000;
            l_pre[k] = -1000;
            l_wrb[k] = -1000;
        end
        for (int i = 0; i < 4; i++) hist[i] = -1000;
        l_col = -1000;
        l_wr  = -1000;
        l_ref = -1000;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cmd_o == 3'd0, "R1 reset command is NOP", int'(cmd_o), 0);
        chk(done_o == 1'b0, "R1 reset done low", int'(done_o), 0);
        chk(req_ready == 1'b1, "R1 reset ready high", int'(req_ready), 1);
        mon_on = 1'b1;

        // R4: closed bank, exact latency
        send(0, 0, 0, 5, 7, 0);
        wait_idle();
        chk(obs_act_cyc - acc_cyc == 2, "R4 ACT latency after accept", obs_act_cyc - acc_cyc, 2);
        chk(obs_col_cyc - obs_act_cyc == T_RCD, "R4 column follows ACT by tRCD",
            obs_col_cyc - obs_act_cyc, T_RCD);
        // R2: row hit, then write and read-after-write (R9)
        send(0, 0, 0, 5, 9, 0);
        send(0, 1, 0, 5, 3, 0);
        send(0, 0, 0, 5, 4, 0);
        // R3 / R10: conflict right after a write
        send(0, 1, 0, 5, 6, 0);
        send(0, 0, 0, 8, 1, 0);
        // R8: activates to five closed banks back to back
        for (int k = 1; k <= 5; k++) send(0, 0, k, 10 + k, k, 0);
        wait_idle();
        chk(mopen[3] == 1'b1, "R5 open-page leaves row open", int'(mopen[3]), 1);
        // R5: close-page write
        send(0, 1, 6, 2, 0, 1);
        wait_idle();
        chk(mopen[6] == 1'b0, "R5 close-page shuts the row", int'(mopen[6]), 0);
        // R11: refresh with several banks open, then an access under tRFC
        send(1, 0, 0, 0, 0, 0);
        send(0, 0, 2, 7, 5, 0);
        wait_idle();
        for (int k = 0; k < BANKS; k++)
            if (k != 2) chk(mopen[k] == 1'b0, "R11 banks closed after refresh", int'(mopen[k]), 0);

        // Random phase
        for (int n = 0; n < 300; n++) begin
            int r;
            r = int'($urandom % 12);
            if (r == 0)
                send(1, 0, 0, 0, 0, 0);
            else
                send(0, bit'($urandom % 2), int'($urandom % 4), int'($urandom % 3),
                     int'($urandom % 1024), (n >= 150) ? bit'($urandom % 2) : 1'b0);
        end
        wait_idle();
        chk(eh == et, "R12 every expected command issued", et - eh, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule